// File: doc/BRIEF.md
# Block-Lock Write-Protect Gate

This block decides, for every write aimed at a 4K x 8 nonvolatile array, whether that write may go ahead. It owns a small protection register that is reached at the highest address of the array, 0xFFF. Three layers of protection stack on each other. The first is a write-enable latch that must be set before any write is accepted. The second is a two-bit selector that shields a region ending at the top of the array: nothing, a quarter, a half or the whole array. The third is a lock bit that, while the external write-protect pin is high, freezes the selector and the lock bit itself.

Write requests arrive on a valid/ready stream carrying a 12-bit address and a data byte. Each accepted request produces exactly one result on an output valid/ready stream, in arrival order. The result carries the address, the data, a permit flag and a flag that marks a register access. A downstream array writer performs only the results that carry a permit. A rejected write is dropped without any error indication. The register image is always visible on a plain output.

Back-pressure follows one rule. The input is ready whenever the output holds no result, or whenever the held result is being taken in the same cycle. A result that is not taken keeps all its fields unchanged. A request is accepted on a rising edge where both valid and ready are high. Its result appears in the next cycle. Any register update it causes shows on the register output in that same next cycle. The write-protect pin is sampled on the accepting edge.

Top module: `wpg_top`

## Requirements
- R1: After reset the register output equals the parameter RESET_VAL with bit 1 (enable latch) forced to 0 and every bit other than 1, 3, 4 and 7 forced to 0, and out_valid is 0.
- R2: A request at address 0xFFF is a register access: its result has out_is_reg=1 and out_permit=0.
- R3: While the enable latch (register bit 1) is 0, every array request (address below 0xFFF) gets out_permit=0.
- R4: With the latch set, an array request is refused exactly when it lies in the shielded region selected by register bits 4:3: 00 none, 01 addresses 0xC00 to 0xFFF, 10 addresses 0x800 to 0xFFF, 11 the whole array.
- R5: A register access made while the latch is 0 loads only bit 1 from data bit 1. Bits 4:3 and 7 are left unchanged.
- R6: A register access made while the latch is 1 and the hardware lock is off loads bit 1, bits 4:3 and bit 7 from the same data bit positions.
- R7: While the write-protect pin is 1 and register bit 7 is 1, a register access leaves bits 4:3 and 7 unchanged but still loads bit 1.
- R8: While the write-protect pin is 0, register bit 7 has no effect, and a register access behaves as in R5 or R6.
- R9: Register bits 0, 2, 5 and 6 always read 0, whatever data is written.
- R10: in_ready is 1 when out_valid is 0 or out_ready is 1. A result held with out_ready=0 keeps out_valid and all its fields stable. Results leave in request order, one for each accepted request.
- R11: Each decision uses the register contents from before the accepting edge. A register access affects only requests accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 12 | Request address; 0xFFF selects the register |
| in_data | input | 8 | Request data byte |
| wp_pin | input | 1 | External write-protect pin |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_permit | output | 1 | Array write allowed |
| out_is_reg | output | 1 | Result was a register access |
| out_addr | output | 12 | Address of the result |
| out_data | output | 8 | Data of the result |
| wpr_value | output | 8 | Current register image |

## Verification
The assertions assume that the stream partner holds out_ready steady between clock edges. They also assume that wp_pin and the request fields are stable around the accepting edge, because the freeze and no-permit properties treat the values seen at that edge as the ones that counted. The stimulus changes wp_pin, the request fields and out_ready only on falling edges, and it lowers in_valid after each accepted request. The output ready pattern stalls the result stream often, so the hold-stable property and the ordering in the scoreboard are exercised while requests are still arriving.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  // bit positions of the protection register image
  localparam int WEL_BIT  = 1;
  localparam int BP_LO    = 3;
  localparam int BP_HI    = 4;
  localparam int LOCK_BIT = 7;

  typedef enum logic [1:0] {
    SHIELD_NONE    = 2'b00,
    SHIELD_QUARTER = 2'b01,
    SHIELD_HALF    = 2'b10,
    SHIELD_ALL     = 2'b11
  } shield_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] shield;
    logic       wel;
  } prot_t;
endpackage

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        shield,
  output logic              hit
);
  import wpg_pkg::*;
  localparam int TOP = ADDR_W - 1;

  logic in_quarter;
  logic in_half;

  always_comb begin
    in_quarter = addr[TOP] & addr[TOP-1];
    in_half    = addr[TOP];
    unique case (shield_e'(shield))
      SHIELD_NONE:    hit = 1'b0;
      SHIELD_QUARTER: hit = in_quarter;
      SHIELD_HALF:    hit = in_half;
      SHIELD_ALL:     hit = 1'b1;
      default:        hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_reg.sv
module wpg_reg #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_pin,
  output wpg_pkg::prot_t    state,
  output logic [DATA_W-1:0] image
);
  import wpg_pkg::*;

  prot_t start_val;
  logic  hw_lock;

  always_comb begin
    start_val.lock   = RESET_VAL[LOCK_BIT];
    start_val.shield = RESET_VAL[BP_HI:BP_LO];
    start_val.wel    = 1'b0;
  end

  assign hw_lock = wp_pin & state.lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= start_val;
    end else if (wr_en) begin
      state.wel <= wr_data[WEL_BIT];
      if (state.wel && !hw_lock) begin
        state.shield <= wr_data[BP_HI:BP_LO];
        state.lock   <= wr_data[LOCK_BIT];
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_img
    if (i == WEL_BIT) begin : g_wel
      assign image[i] = state.wel;
    end else if (i == BP_LO) begin : g_bp0
      assign image[i] = state.shield[0];
    end else if (i == BP_HI) begin : g_bp1
      assign image[i] = state.shield[1];
    end else if (i == LOCK_BIT) begin : g_lock
      assign image[i] = state.lock;
    end else begin : g_zero
      assign image[i] = 1'b0;
    end
  end

  AST_LATCH_GATES_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !state.wel) |=> $stable(state.shield) && $stable(state.lock)); // R5
  AST_PIN_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && state.lock) |=> $stable(state.shield) && $stable(state.lock)); // R7
endmodule

// File: rtl/wpg_out_stage.sv
module wpg_out_stage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              permit_d,
  input  logic              is_reg_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  output logic              slot_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_permit,
  output logic              out_is_reg,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_permit <= 1'b0;
      out_is_reg <= 1'b0;
      out_addr   <= '0;
      out_data   <= '0;
    end else if (slot_free) begin
      out_valid <= take;
      if (take) begin
        out_permit <= permit_d;
        out_is_reg <= is_reg_d;
        out_addr   <= addr_d;
        out_data   <= data_d;
      end
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_data)
      && $stable(out_permit) && $stable(out_is_reg)); // R10
endmodule

// File: rtl/wpg_top.sv
module wpg_top #(
  parameter int         ADDR_W    = 12,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              wp_pin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_permit,
  output logic              out_is_reg,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] wpr_value
);
  import wpg_pkg::*;

  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  prot_t prot;
  logic  accept;
  logic  is_reg;
  logic  in_shield;
  logic  permit_d;

  assign accept   = in_valid && in_ready;
  assign is_reg   = (in_addr == REG_ADDR);
  assign permit_d = !is_reg && prot.wel && !in_shield;

  wpg_region #(.ADDR_W(ADDR_W)) u_region (
    .addr   (in_addr),
    .shield (prot.shield),
    .hit    (in_shield)
  );

  wpg_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && is_reg),
    .wr_data (in_data),
    .wp_pin  (wp_pin),
    .state   (prot),
    .image   (wpr_value)
  );

  wpg_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (accept),
    .permit_d   (permit_d),
    .is_reg_d   (is_reg),
    .addr_d     (in_addr),
    .data_d     (in_data),
    .slot_free  (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_permit (out_permit),
    .out_is_reg (out_is_reg),
    .out_addr   (out_addr),
    .out_data   (out_data)
  );

  AST_REG_ACCESS_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_reg) |=> out_valid && out_is_reg && !out_permit); // R2
  AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wpr_value[WEL_BIT]) |=> !out_permit); // R3
  AST_FULL_SHIELD_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wpr_value[BP_HI:BP_LO] == 2'b11) |=> !out_permit); // R4
endmodule

// File: tb/wpg_top_bench.sv
module wpg_top_bench;
  localparam logic [7:0] RST_VAL = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic wp_pin = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic out_permit, out_is_reg;
  logic [11:0] out_addr;
  logic [7:0] out_data;
  logic [7:0] wpr_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit flow = 1'b0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  // bench model of the register fields
  logic m_wel, m_lock;
  logic [1:0] m_sh;

  always #5 clk = ~clk;

  wpg_top #(.RESET_VAL(RST_VAL)) u_wpg_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .wp_pin(wp_pin),
    .out_valid(out_valid), .out_ready(out_ready), .out_permit(out_permit),
    .out_is_reg(out_is_reg), .out_addr(out_addr), .out_data(out_data),
    .wpr_value(wpr_value)
  );

  function automatic logic [7:0] model_img();
    return {m_lock, 2'b00, m_sh, 1'b0, m_wel, 1'b0};
  endfunction

  function automatic logic shielded(logic [11:0] a, logic [1:0] s);
    case (s)
      2'b00: return 1'b0;
      2'b01: return a >= 12'hC00;
      2'b10: return a >= 12'h800;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [11:0] a, logic [7:0] d);
    logic reg_acc, perm;
    string tg;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    reg_acc = (a == 12'hFFF);
    perm = !reg_acc && m_wel && !shielded(a, m_sh);
    tg = reg_acc ? "R2" : (!m_wel ? "R3" : "R4");
    exp_q.push_back({perm, reg_acc, a, d});
    tag_q.push_back(tg);
    // R11: model updated only after decision
    if (reg_acc) begin
      if (m_wel && !(wp_pin && m_lock)) begin
        m_sh = d[4:3];
        m_lock = d[7];
      end
      m_wel = d[1];
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    if (reg_acc) check("R5/R6/R7/R8/R9 register image", wpr_value, model_img());
  endtask

  // output ready pattern with frequent stalls
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = flow && (cyc % 5 != 2) && (cyc % 7 != 3);
    end
  end

  // monitor: pops expected items as results leave
  initial begin
    bit stalled = 1'b0;
    logic [21:0] held = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (stalled) begin
          check("R10 held result valid", out_valid, 1'b1);
          check("R10 held result fields", {out_permit, out_is_reg, out_addr, out_data}, held);
        end
        stalled = out_valid && !out_ready;
        held = {out_permit, out_is_reg, out_addr, out_data};
        check("R10 ready rule", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R10 unexpected result", 1, 0);
          end else begin
            logic [21:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " result"}, {out_permit, out_is_reg, out_addr, out_data}, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_wel = 1'b0;
    m_sh = RST_VAL[4:3];
    m_lock = RST_VAL[7];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset image", wpr_value, 8'h98);
    check("R1 reset out_valid", out_valid, 1'b0);
    flow = 1'b1;

    wp_pin = 1'b1;
    send(12'h123, 8'h55);          // R3 denied, latch clear
    send(12'hFFF, 8'h18);          // R5 only latch bit loads
    send(12'hFFF, 8'h02);          // R5 sets latch
    send(12'h000, 8'h11);          // R4 whole array shielded
    send(12'hFFF, 8'h00);          // R7 fields frozen, latch clears
    send(12'hFFF, 8'h02);
    send(12'hFFF, 8'h08);          // R7 still frozen
    @(negedge clk); wp_pin = 1'b0; // R8 pin low
    send(12'hFFF, 8'h02);
    send(12'hFFF, 8'h0A);          // R6 quarter, lock off
    send(12'hBFF, 8'hA1);
    send(12'hC00, 8'hA2);
    send(12'hFFE, 8'hA3);
    send(12'h000, 8'hA4);
    send(12'hFFF, 8'h12);          // R6 half
    send(12'h7FF, 8'hB1);
    send(12'h800, 8'hB2);
    send(12'hFFF, 8'h02);          // R6 none
    send(12'hFFE, 8'hC1);
    send(12'h000, 8'hC2);
    send(12'hFFF, 8'hFF);          // R9 unused bits zero, lock set
    send(12'hFFF, 8'h0A);          // R8 lock ignored while pin low
    send(12'hFFF, 8'h9A);
    @(negedge clk); wp_pin = 1'b1;
    send(12'hFFF, 8'h02);          // R7 frozen under pin
    send(12'hFFF, 8'h00);
    send(12'h400, 8'hD1);          // R3
    for (int i = 0; i < 20; i++) begin
      send(12'(i * 200), 8'(i));   // R10 ordering under stalls
    end
    repeat (30) @(posedge clk);
    check("R10 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule